// File: doc/BRIEF.md
# Configurable Ordering Store Buffer

This block sits between one core's load/store request port and the memory port. It holds the core's stores in a small buffer and retires them to memory in the background. A mode input chooses between three memory-ordering disciplines. In sequentially consistent operation, a load waits until every earlier store has reached memory. In total-store-order operation, loads may overtake buffered stores, but the stores retire strictly in program order. In partial-store-order operation, loads overtake stores as well, and stores may retire out of program order. Stores to the same address always keep their relative order.

A fence request is accepted only once the buffer is empty, so nothing after it can run ahead of an older store. When ordering permits, a load that hits a buffered address is answered from the youngest matching entry. Such a load never reaches memory. The memory port uses a valid/ready handshake, and read data is taken in the handshake cycle. A load's response appears on the core side one cycle after the load is accepted.

Top module: `ord_store_buf`

## Requirements
- R1: After reset, the buffer is empty: `resp_valid_o` and `mem_valid_o` are low, and a store request sees `req_ready_o` high.
- R2: In mode 0 (sequential consistency), a load is not accepted while any store is buffered, even if its address matches one. It is then accepted together with its memory read once the buffer is empty and `mem_ready_i` is high.
- R3: In modes 1 (total store order) and 0, buffered stores are written to memory strictly in the order they were accepted.
- R4: In modes 1 and 2, a load that matches no buffered store takes the memory port ahead of pending stores. It appears as `mem_valid_o`=1 with `mem_write_o`=0 and the load address. No store is written in the cycle the load is accepted.
- R5: In modes 1 and 2, a load matching one or more buffered stores is accepted without using memory and returns the data of the youngest matching store.
- R6: In mode 2 (partial store order), a rotation index starts at 0 after reset and advances by one, modulo the depth, on each retired store. The retired entry is the first eligible entry, in age order, at a position at or above the index. If there is none, it is the first eligible entry overall. An entry is eligible when no older buffered entry has the same address.
- R7: In mode 2, two stores to the same address reach memory in program order.
- R8: An operation code with bit 1 set (a fence) has `req_ready_o` low until the buffer is empty.
- R9: A store request sees `req_ready_o` low while the buffer holds DEPTH entries.
- R10: The mode input is sampled only in cycles when the buffer is empty; mode 3 acts as mode 1. A change made while stores are buffered has no effect on how those stores retire.
- R11: Operation code 0 is a load and 1 a store. `resp_valid_o` is high for exactly the cycle after a load is accepted, with the loaded value on `resp_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Ordering mode: 0 sequential, 1 total store, 2 partial store |
| req_valid_i | input | 1 | Core request valid |
| req_op_i | input | 2 | 0 load, 1 store, 2 or 3 fence |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Store data |
| req_ready_o | output | 1 | Request accepted when high with valid |
| resp_valid_o | output | 1 | Load response valid |
| resp_rdata_o | output | DW | Load response data |
| mem_valid_o | output | 1 | Memory request valid |
| mem_write_o | output | 1 | 1 write (retiring store), 0 read (load) |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rdata_i | input | DW | Read data, valid in the handshake cycle |

## Verification
The hardest situations to reach are out-of-order retirement and the hazard between stores to the same address. Both show up only when several stores are queued at once and are then released back to back. The stimulus therefore holds `mem_ready_i` low while it fills the buffer with a chosen address pattern. It then raises `mem_ready_i` and records the order of the memory writes. The same hold-then-release technique exposes the stalls: fence waiting, a full buffer, a sequentially consistent load, and a mode change attempted while stores are pending.

// File: rtl/osb_pkg.sv
package osb_pkg;

   typedef enum logic [1:0] {
      MODE_SC  = 2'd0,
      MODE_TSO = 2'd1,
      MODE_PSO = 2'd2,
      MODE_RSV = 2'd3
   } osb_mode_e;

   typedef enum logic [1:0] {
      OP_LOAD   = 2'd0,
      OP_STORE  = 2'd1,
      OP_FENCE  = 2'd2,
      OP_FENCEX = 2'd3
   } osb_op_e;

   localparam int POL_ROTATE = 0;
   localparam int POL_OLDEST = 1;

endpackage

// File: rtl/osb_queue.sv
module osb_queue #(
   parameter int DEPTH = 4,
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int IW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      push_i,
   input  logic [AW-1:0]             push_addr_i,
   input  logic [DW-1:0]             push_data_i,
   input  logic                      pop_i,
   input  logic [IW-1:0]             pop_idx_i,
   output logic [DEPTH-1:0]          vld_o,
   output logic [DEPTH-1:0][AW-1:0]  addr_o,
   output logic [DEPTH-1:0][DW-1:0]  data_o,
   output logic [CW-1:0]             occ_o
);

   logic [DEPTH-1:0]          vld_q, vld_n;
   logic [DEPTH-1:0][AW-1:0]  addr_q, addr_n;
   logic [DEPTH-1:0][DW-1:0]  data_q, data_n;
   logic [DEPTH:0]            ext_v;
   logic [DEPTH:0][AW-1:0]    ext_a;
   logic [DEPTH:0][DW-1:0]    ext_d;
   logic [CW-1:0]             occ;
   logic [CW-1:0]             slot_free;

   always_comb begin
      occ = '0;
      for (int i = 0; i < DEPTH; i++) begin
         occ = occ + CW'(vld_q[i]);
      end
   end

   // Entries stay packed toward index 0 in age order; a removal closes the gap.
   always_comb begin
      ext_v            = {1'b0, vld_q};
      ext_a[DEPTH]     = '0;
      ext_d[DEPTH]     = '0;
      ext_a[DEPTH-1:0] = addr_q;
      ext_d[DEPTH-1:0] = data_q;
      slot_free        = occ - CW'(pop_i);
      for (int i = 0; i < DEPTH; i++) begin
         if (pop_i && (IW'(i) >= pop_idx_i)) begin
            vld_n[i]  = ext_v[i+1];
            addr_n[i] = ext_a[i+1];
            data_n[i] = ext_d[i+1];
         end else begin
            vld_n[i]  = vld_q[i];
            addr_n[i] = addr_q[i];
            data_n[i] = data_q[i];
         end
         if (push_i && (CW'(i) == slot_free)) begin
            vld_n[i]  = 1'b1;
            addr_n[i] = push_addr_i;
            data_n[i] = push_data_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         vld_q  <= vld_n;
         addr_q <= addr_n;
         data_q <= data_n;
      end
   end

   assign vld_o  = vld_q;
   assign addr_o = addr_q;
   assign data_o = data_q;
   assign occ_o  = occ;

endmodule

// File: rtl/osb_fwd.sv
module osb_fwd #(
   parameter int DEPTH = 4,
   parameter int AW    = 8,
   parameter int DW    = 16
) (
   input  logic [DEPTH-1:0]          vld_i,
   input  logic [DEPTH-1:0][AW-1:0]  addr_i,
   input  logic [DEPTH-1:0][DW-1:0]  data_i,
   input  logic [AW-1:0]             look_addr_i,
   output logic                      hit_o,
   output logic [DW-1:0]             data_o
);

   // Later (younger) matches overwrite earlier ones.
   always_comb begin
      hit_o  = 1'b0;
      data_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (vld_i[i] && (addr_i[i] == look_addr_i)) begin
            hit_o  = 1'b1;
            data_o = data_i[i];
         end
      end
   end

endmodule

// File: rtl/osb_drain_sel.sv
module osb_drain_sel
   import osb_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int AW     = 8,
   parameter int POLICY = POL_ROTATE,
   parameter int IW     = $clog2(DEPTH)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [DEPTH-1:0]          vld_i,
   input  logic [DEPTH-1:0][AW-1:0]  addr_i,
   input  logic                      pso_i,
   input  logic                      adv_i,
   output logic                      cand_valid_o,
   output logic [IW-1:0]             cand_idx_o
);

   logic [DEPTH-1:0] elig;
   logic             lo_found;
   logic [IW-1:0]    lo_idx;
   logic             pso_v;
   logic [IW-1:0]    pso_idx;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         elig[i] = vld_i[i];
         for (int j = 0; j < i; j++) begin
            if (vld_i[j] && (addr_i[j] == addr_i[i])) begin
               elig[i] = 1'b0;
            end
         end
      end
   end

   always_comb begin
      lo_found = 1'b0;
      lo_idx   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (elig[i] && !lo_found) begin
            lo_found = 1'b1;
            lo_idx   = IW'(i);
         end
      end
   end

   if (POLICY == POL_ROTATE) begin : g_rotate
      logic [IW-1:0] rot_q;
      logic          hi_found;
      logic [IW-1:0] hi_idx;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rot_q <= '0;
         end else if (adv_i && pso_i) begin
            rot_q <= (rot_q == IW'(DEPTH - 1)) ? '0 : rot_q + 1'b1;
         end
      end

      always_comb begin
         hi_found = 1'b0;
         hi_idx   = '0;
         for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && !hi_found && (IW'(i) >= rot_q)) begin
               hi_found = 1'b1;
               hi_idx   = IW'(i);
            end
         end
         pso_v   = lo_found;
         pso_idx = hi_found ? hi_idx : lo_idx;
      end
   end else begin : g_oldest
      always_comb begin
         pso_v   = lo_found;
         pso_idx = lo_idx;
      end
   end

   assign cand_valid_o = pso_i ? pso_v : vld_i[0];
   assign cand_idx_o   = pso_i ? pso_idx : '0;

endmodule

// File: rtl/ord_store_buf.sv
module ord_store_buf
   import osb_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int AW     = 8,
   parameter int DW     = 16,
   parameter int POLICY = POL_ROTATE
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [1:0]     mode_i,
   input  logic           req_valid_i,
   input  logic [1:0]     req_op_i,
   input  logic [AW-1:0]  req_addr_i,
   input  logic [DW-1:0]  req_wdata_i,
   output logic           req_ready_o,
   output logic           resp_valid_o,
   output logic [DW-1:0]  resp_rdata_o,
   output logic           mem_valid_o,
   output logic           mem_write_o,
   output logic [AW-1:0]  mem_addr_o,
   output logic [DW-1:0]  mem_wdata_o,
   input  logic           mem_ready_i,
   input  logic [DW-1:0]  mem_rdata_i
);

   localparam int IW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ord_store_buf: DEPTH must be at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("ord_store_buf: AW and DW must be positive");
   end
   if (POLICY != POL_ROTATE && POLICY != POL_OLDEST) begin : g_bad_policy
      $error("ord_store_buf: unknown POLICY");
   end

   osb_mode_e                 mode_q;
   logic [DEPTH-1:0]          q_vld;
   logic [DEPTH-1:0][AW-1:0]  q_addr;
   logic [DEPTH-1:0][DW-1:0]  q_data;
   logic [CW-1:0]             q_occ;
   logic                      fwd_hit;
   logic [DW-1:0]             fwd_data;
   logic                      cand_valid;
   logic [IW-1:0]             cand_idx;
   logic                      is_sc, is_pso, empty, full;
   logic                      op_load, op_store, op_fence;
   logic                      load_fwd, load_mem, mem_load_req;
   logic                      accept, push, pop;
   logic                      resp_v_q;
   logic [DW-1:0]             resp_d_q;

   // Mode register: sampled only while nothing is buffered.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= MODE_SC;
      end else if (q_occ == '0) begin
         mode_q <= (mode_i == MODE_RSV) ? MODE_TSO : osb_mode_e'(mode_i);
      end
   end

   assign is_sc    = (mode_q == MODE_SC);
   assign is_pso   = (mode_q == MODE_PSO);
   assign empty    = (q_occ == '0);
   assign full     = (q_occ == CW'(DEPTH));
   assign op_load  = (req_op_i == OP_LOAD);
   assign op_store = (req_op_i == OP_STORE);
   assign op_fence = req_op_i[1];

   assign load_fwd     = op_load && !is_sc && fwd_hit;
   assign load_mem     = op_load && !load_fwd && (!is_sc || empty);
   assign mem_load_req = req_valid_i && load_mem;

   always_comb begin
      if (op_store)      req_ready_o = !full;
      else if (op_fence) req_ready_o = empty;
      else if (load_fwd) req_ready_o = 1'b1;
      else if (load_mem) req_ready_o = mem_ready_i;
      else               req_ready_o = 1'b0;
   end

   assign accept = req_valid_i && req_ready_o;
   assign push   = accept && op_store;
   assign pop    = cand_valid && !mem_load_req && mem_ready_i;

   osb_queue #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .DW    (DW),
      .IW    (IW),
      .CW    (CW)
   ) u_queue (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push),
      .push_addr_i (req_addr_i),
      .push_data_i (req_wdata_i),
      .pop_i       (pop),
      .pop_idx_i   (cand_idx),
      .vld_o       (q_vld),
      .addr_o      (q_addr),
      .data_o      (q_data),
      .occ_o       (q_occ)
   );

   osb_fwd #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .DW    (DW)
   ) u_fwd (
      .vld_i       (q_vld),
      .addr_i      (q_addr),
      .data_i      (q_data),
      .look_addr_i (req_addr_i),
      .hit_o       (fwd_hit),
      .data_o      (fwd_data)
   );

   osb_drain_sel #(
      .DEPTH  (DEPTH),
      .AW     (AW),
      .POLICY (POLICY),
      .IW     (IW)
   ) u_sel (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .vld_i        (q_vld),
      .addr_i       (q_addr),
      .pso_i        (is_pso),
      .adv_i        (pop),
      .cand_valid_o (cand_valid),
      .cand_idx_o   (cand_idx)
   );

   // Memory port: a load miss takes priority over retiring a store.
   assign mem_valid_o = mem_load_req || cand_valid;
   assign mem_write_o = !mem_load_req;
   assign mem_addr_o  = mem_load_req ? req_addr_i : q_addr[cand_idx];
   assign mem_wdata_o = q_data[cand_idx];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         resp_v_q <= 1'b0;
         resp_d_q <= '0;
      end else begin
         resp_v_q <= accept && op_load;
         if (accept && op_load) begin
            resp_d_q <= load_fwd ? fwd_data : mem_rdata_i;
         end
      end
   end

   assign resp_valid_o = resp_v_q;
   assign resp_rdata_o = resp_d_q;

endmodule

// File: rtl/osb_checker.sv
module osb_checker #(
   parameter int DEPTH = 4,
   parameter int AW    = 8,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic [1:0]     mode_q_i,
   input logic [CW-1:0]  occ_i,
   input logic           req_valid_i,
   input logic [1:0]     req_op_i,
   input logic           req_ready_i,
   input logic           resp_valid_i,
   input logic           mem_valid_i,
   input logic           mem_write_i,
   input logic [AW-1:0]  mem_addr_i,
   input logic [AW-1:0]  head_addr_i
);

   assert_occ_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_i <= CW'(DEPTH));

   assert_no_store_when_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ_i == CW'(DEPTH)) |-> !(req_valid_i && req_op_i == 2'd1 && req_ready_i));

   assert_sc_load_after_drain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q_i == 2'd0 && req_valid_i && req_op_i == 2'd0 && req_ready_i) |-> occ_i == '0);

   assert_fence_needs_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_op_i[1] && req_ready_i) |-> occ_i == '0);

   assert_mode_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ_i != '0) |=> $stable(mode_q_i));

   assert_head_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_valid_i && mem_write_i && mode_q_i != 2'd2) |-> mem_addr_i == head_addr_i);

   assert_resp_after_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_valid_i |-> $past(req_valid_i && req_op_i == 2'd0 && req_ready_i));

endmodule

bind ord_store_buf osb_checker #(
   .DEPTH (DEPTH),
   .AW    (AW),
   .CW    (CW)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .mode_q_i     (mode_q),
   .occ_i        (q_occ),
   .req_valid_i  (req_valid_i),
   .req_op_i     (req_op_i),
   .req_ready_i  (req_ready_o),
   .resp_valid_i (resp_valid_o),
   .mem_valid_i  (mem_valid_o),
   .mem_write_i  (mem_write_o),
   .mem_addr_i   (mem_addr_o),
   .head_addr_i  (q_addr[0])
);

// File: tb/ord_store_buf_tb.sv
module ord_store_buf_tb;

   localparam int DEPTH = 4;
   localparam int AW    = 8;
   localparam int DW    = 16;
   localparam int NVEC  = 10;

   // {op[1:0], addr[7:0], data[15:0], expected load data[15:0]}
   localparam logic [41:0] VEC [0:NVEC-1] = '{
      {2'd1, 8'h10, 16'hAAAA, 16'h0000},
      {2'd0, 8'h10, 16'h0000, 16'hAAAA},
      {2'd1, 8'h20, 16'h1111, 16'h0000},
      {2'd1, 8'h20, 16'h2222, 16'h0000},
      {2'd0, 8'h20, 16'h0000, 16'h2222},
      {2'd0, 8'h30, 16'h0000, 16'hC030},
      {2'd1, 8'h31, 16'h0BEE, 16'h0000},
      {2'd2, 8'h00, 16'h0000, 16'h0000},
      {2'd0, 8'h31, 16'h0000, 16'h0BEE},
      {2'd0, 8'h10, 16'h0000, 16'hAAAA}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [1:0]     mode_r = 2'd1;
   logic           req_v = 1'b0;
   logic [1:0]     req_op = 2'd1;
   logic [AW-1:0]  req_a = '0;
   logic [DW-1:0]  req_d = '0;
   logic           req_ready;
   logic           resp_valid;
   logic [DW-1:0]  resp_rdata;
   logic           mem_valid, mem_write;
   logic [AW-1:0]  mem_addr;
   logic [DW-1:0]  mem_wdata;
   logic           mem_rdy = 1'b1;
   logic [DW-1:0]  mem_rdata;

   logic [DW-1:0]  bmem [0:255];
   logic [AW-1:0]  log_a [0:63];
   logic [DW-1:0]  log_d [0:63];
   int             log_n = 0;
   int             n_chk = 0;
   int             n_fail = 0;
   int             acc_log;
   int             base;
   logic           rsp_v;
   logic [DW-1:0]  rsp_d;

   always #10 clk = ~clk;

   ord_store_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .mode_i       (mode_r),
      .req_valid_i  (req_v),
      .req_op_i     (req_op),
      .req_addr_i   (req_a),
      .req_wdata_i  (req_d),
      .req_ready_o  (req_ready),
      .resp_valid_o (resp_valid),
      .resp_rdata_o (resp_rdata),
      .mem_valid_o  (mem_valid),
      .mem_write_o  (mem_write),
      .mem_addr_o   (mem_addr),
      .mem_wdata_o  (mem_wdata),
      .mem_ready_i  (mem_rdy),
      .mem_rdata_i  (mem_rdata)
   );

   assign mem_rdata = bmem[mem_addr];

   // Memory model and write log.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) bmem[i] = 16'hC000 | 16'(i);
      end else if (mem_valid && mem_rdy && mem_write) begin
         bmem[mem_addr] = mem_wdata;
         if (log_n < 64) begin
            log_a[log_n] = mem_addr;
            log_d[log_n] = mem_wdata;
         end
         log_n = log_n + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   task automatic present(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_v  = 1'b1;
      req_op = op;
      req_a  = a;
      req_d  = d;
   endtask

   task automatic complete();
      int w;
      w = 0;
      #1;
      while (!req_ready && w < 500) begin
         @(negedge clk);
         #1;
         w++;
      end
      if (w >= 500) chk("accept timeout", 32'd0, 32'd1);
      @(posedge clk);
      #1;
      req_v   = 1'b0;
      acc_log = log_n;
      @(negedge clk);
      rsp_v = resp_valid;
      rsp_d = resp_rdata;
   endtask

   task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      present(op, a, d);
      complete();
   endtask

   task automatic expect_stall(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         #1;
         chk(tag, 32'(req_ready), 32'd0);
         @(negedge clk);
      end
   endtask

   task automatic wait_log(input int target);
      int w;
      w = 0;
      while (log_n < target && w < 500) begin
         @(negedge clk);
         w++;
      end
      if (w >= 500) chk("drain timeout", 32'(log_n), 32'(target));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 resp_valid", 32'(resp_valid), 32'd0);
      chk("R1 mem_valid", 32'(mem_valid), 32'd0);
      chk("R1 store ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // Vector table, total store order, memory always ready (R11, R5)
      for (int v = 0; v < NVEC; v++) begin
         do_op(VEC[v][41:40], VEC[v][39:32], VEC[v][31:16]);
         if (VEC[v][41:40] == 2'd0) begin
            chk($sformatf("R11 vec%0d valid", v), 32'(rsp_v), 32'd1);
            chk($sformatf("R11 vec%0d data", v), 32'(rsp_d), 32'(VEC[v][15:0]));
         end
      end
      repeat (4) @(negedge clk);

      // R5: forwarding from youngest match while memory is stalled
      mem_rdy = 1'b0;
      base = log_n;
      do_op(2'd1, 8'h40, 16'h0005);
      do_op(2'd1, 8'h40, 16'h0006);
      do_op(2'd0, 8'h40, 16'h0000);
      chk("R5 forward data", 32'(rsp_d), 32'h0006);
      chk("R5 no memory write", 32'(log_n), 32'(base));

      // R4: load miss passes the pending stores
      present(2'd0, 8'h50, 16'h0000);
      #1;
      chk("R4 mem_valid", 32'(mem_valid), 32'd1);
      chk("R4 mem_write", 32'(mem_write), 32'd0);
      chk("R4 mem_addr", 32'(mem_addr), 32'h50);
      chk("R4 stalled on memory", 32'(req_ready), 32'd0);
      @(negedge clk);
      mem_rdy = 1'b1;
      complete();
      chk("R4 no write at load", 32'(acc_log), 32'(base));
      chk("R4 load data", 32'(rsp_d), 32'hC050);
      wait_log(base + 2);
      chk("R3 first 40 data", 32'(log_d[base]), 32'h0005);
      chk("R3 second 40 data", 32'(log_d[base + 1]), 32'h0006);

      // R3/R9/R10: fill in total store order, request partial order while full
      mem_rdy = 1'b0;
      base = log_n;
      do_op(2'd1, 8'h63, 16'h0001);
      do_op(2'd1, 8'h61, 16'h0002);
      do_op(2'd1, 8'h62, 16'h0003);
      do_op(2'd1, 8'h60, 16'h0004);
      mode_r = 2'd2;
      present(2'd1, 8'h64, 16'h0005);
      expect_stall(3, "R9 full stall");
      mem_rdy = 1'b1;
      complete();
      wait_log(base + 5);
      chk("R10 order 0", 32'(log_a[base]),     32'h63);
      chk("R10 order 1", 32'(log_a[base + 1]), 32'h61);
      chk("R3 order 2",  32'(log_a[base + 2]), 32'h62);
      chk("R3 order 3",  32'(log_a[base + 3]), 32'h60);
      chk("R9 fifth",    32'(log_a[base + 4]), 32'h64);
      repeat (3) @(negedge clk);

      // R6: rotating retirement in partial store order
      mem_rdy = 1'b0;
      base = log_n;
      do_op(2'd1, 8'h70, 16'h0001);
      do_op(2'd1, 8'h71, 16'h0002);
      do_op(2'd1, 8'h72, 16'h0003);
      do_op(2'd1, 8'h73, 16'h0004);
      @(negedge clk);
      mem_rdy = 1'b1;
      wait_log(base + 4);
      chk("R6 order 0", 32'(log_a[base]),     32'h70);
      chk("R6 order 1", 32'(log_a[base + 1]), 32'h72);
      chk("R6 order 2", 32'(log_a[base + 2]), 32'h71);
      chk("R6 order 3", 32'(log_a[base + 3]), 32'h73);

      // R7: same-address pair keeps order under partial store order
      mem_rdy = 1'b0;
      base = log_n;
      do_op(2'd1, 8'h81, 16'h0001);
      do_op(2'd1, 8'h80, 16'h0002);
      do_op(2'd1, 8'h80, 16'h0003);
      do_op(2'd1, 8'h82, 16'h0004);
      @(negedge clk);
      mem_rdy = 1'b1;
      wait_log(base + 4);
      chk("R7 order 0", 32'(log_a[base]),     32'h81);
      chk("R7 order 1", 32'(log_a[base + 1]), 32'h82);
      chk("R7 older 80", 32'(log_d[base + 2]), 32'h0002);
      chk("R7 younger 80", 32'(log_d[base + 3]), 32'h0003);
      chk("R7 final memory", 32'(bmem[8'h80]), 32'h0003);

      // R8: fence waits for the buffer to drain
      mem_rdy = 1'b0;
      base = log_n;
      do_op(2'd1, 8'h90, 16'h0099);
      present(2'd2, 8'h00, 16'h0000);
      expect_stall(3, "R8 fence stall");
      mem_rdy = 1'b1;
      complete();
      chk("R8 store before fence", 32'(acc_log), 32'(base + 1));

      // R2: sequential consistency, load waits even on an address hit
      mode_r = 2'd0;
      repeat (3) @(negedge clk);
      mem_rdy = 1'b0;
      base = log_n;
      do_op(2'd1, 8'hA0, 16'h7777);
      present(2'd0, 8'hA0, 16'h0000);
      expect_stall(3, "R2 load stall");
      mem_rdy = 1'b1;
      complete();
      chk("R2 store drained first", 32'(acc_log), 32'(base + 1));
      chk("R2 load data", 32'(rsp_d), 32'h7777);

      summary();
      $finish;
   end

endmodule